// File: doc/BRIEF.md
# Memory Access Unit with Address and Data Holding Registers

This unit sits between the step sequencer of a processor datapath and a memory whose latency is not fixed. The datapath puts an address into an address-holding register and, for stores, a value into a data-holding register. A one-step command then starts a load or a store. The memory always takes its address from the address register and its store data from the data register. Load data returned by the memory always lands in the data register.

Starting an access and waiting for it are separate commands. After a load or store has been started, the sequencer may run unrelated steps while the memory works. It stalls only when it raises the wait command, and only while the access is still unfinished. Wait may be raised in the same step that starts the access. Wait with nothing outstanding costs no cycle. Only one access may be outstanding at a time. A second start while one is pending is rejected and flagged. A datapath write to either holding register while an access is pending is blocked and flagged.

Top module: `mem_access_unit`

## Requirements
- R1: After reset, both holding registers read zero, and `busy`, `stall`, `mem_req_valid`, `err_issue` and `err_clobber` are low.
- R2: While no access is outstanding, `mar_load` or `mdr_load` writes the matching input into its register at the clock edge. Without a load, each register keeps its value.
- R3: The command code on `step_cmd` is 0 none, 1 load, 2 store, 3 none. A load accepted while idle raises `mem_req_valid` with `mem_req_we` low from the next cycle. The request is held, with a stable address equal to the address register, until `mem_req_ready` is seen high.
- R4: A store accepted while idle presents `mem_req_we` high, the address register on `mem_req_addr` and the data register on `mem_req_wdata`. It finishes in the cycle where `mem_req_ready` is high.
- R5: After its request is accepted, a load waits for `mem_rsp_valid`. In that cycle the load finishes, and at the clock edge `mem_rsp_data` is written into the data register and `busy` falls.
- R6: `stall` is high exactly when `step_wait` is high and an access is outstanding that does not finish in that cycle. Wait with no access outstanding gives `stall` low in the same cycle.
- R7: Wait raised in the same step as an accepted load or store gives `stall` high in that step.
- R8: A load or store command while an access is outstanding sets `err_issue` in that cycle. The command is dropped, so no further request follows the current one.
- R9: `mar_load` or `mdr_load` while an access is outstanding sets `err_clobber` in that cycle and leaves both registers unchanged.
- R10: `mem_rsp_valid` while no load is awaiting data, and command code 3, have no effect on the data register or on the memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_cmd | input | 2 | Access command for this step (0 none, 1 load, 2 store, 3 none) |
| step_wait | input | 1 | Wait for the outstanding access to finish |
| mar_load | input | 1 | Write `mar_din` into the address register |
| mar_din | input | AW | Address from the datapath |
| mdr_load | input | 1 | Write `mdr_din` into the data register |
| mdr_din | input | DW | Data from the datapath |
| mar_q | output | AW | Address register contents |
| mdr_q | output | DW | Data register contents |
| busy | output | 1 | An access is outstanding |
| stall | output | 1 | Sequencer must repeat the current wait step |
| err_issue | output | 1 | Start command rejected because an access is outstanding |
| err_clobber | output | 1 | Register write blocked because an access is outstanding |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a store |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Store data |
| mem_rsp_valid | input | 1 | Load data present |
| mem_rsp_data | input | DW | Load data |

## Verification
The assertions assume that the memory never returns load data in the same cycle in which it accepts the request, so a response always comes one or more cycles after acceptance. They also assume that, while `stall` is high, the sequencer repeats only the wait and issues no new start command. The bench memory model raises `mem_rsp_valid` only after `mem_req_ready` has been dropped. The stimulus clears `step_cmd` in every step after a start. Stray responses and blocked commands are driven only in the directed cases that test their rejection.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_STORE = 2'd2,
    CMD_NOP3  = 2'd3
  } mau_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_RSP  = 2'd2
  } mau_phase_e;

  // A command code that starts a memory access
  function automatic logic cmd_starts_access(input logic [1:0] code);
    return (code == CMD_LOAD) || (code == CMD_STORE);
  endfunction

  // Stall rule: wait is held off while an access is pending and not ending now
  function automatic logic wait_blocks(input logic wait_req, input logic started,
                                       input logic pending, input logic ending);
    return wait_req && (started || (pending && !ending));
  endfunction

  // Datapath register write attempted during an access
  function automatic logic write_blocked(input logic pending, input logic ld_a,
                                         input logic ld_d);
    return pending && (ld_a || ld_d);
  endfunction

endpackage

// File: rtl/mau_seq.sv
module mau_seq
  import mau_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmd,
  input  logic       req_ready,
  input  logic       rsp_valid,
  output logic       busy,
  output logic       start_ok,
  output logic       start_err,
  output logic       req_valid,
  output logic       req_we,
  output logic       finish,
  output logic       fill
);

  mau_phase_e phase_q, phase_d;
  logic       we_q;
  logic       is_start;
  logic       accept;

  assign is_start  = cmd_starts_access(cmd);
  assign start_ok  = is_start && (phase_q == PH_IDLE);
  assign start_err = is_start && (phase_q != PH_IDLE);
  assign busy      = (phase_q != PH_IDLE);
  assign req_valid = (phase_q == PH_REQ);
  assign req_we    = we_q;
  assign accept    = req_valid && req_ready;
  assign fill      = (phase_q == PH_RSP) && rsp_valid;
  assign finish    = (accept && we_q) || fill;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_ok) phase_d = PH_REQ;
      PH_REQ:  if (accept)   phase_d = we_q ? PH_IDLE : PH_RSP;
      PH_RSP:  if (rsp_valid) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      we_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (start_ok) we_q <= (cmd == CMD_STORE);
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_we)));

  assert_one_flight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  assert_store_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we) |=> !busy);

endmodule

// File: rtl/mau_regs.sv
module mau_regs
  import mau_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          mar_load,
  input  logic [AW-1:0] mar_din,
  input  logic          mdr_load,
  input  logic [DW-1:0] mdr_din,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] mdr_q,
  output logic          clobber
);

  logic mar_we;
  logic mdr_we;

  assign clobber = write_blocked(busy, mar_load, mdr_load);
  assign mar_we  = mar_load && !busy;
  assign mdr_we  = mdr_load && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q <= '0;
      mdr_q <= '0;
    end else begin
      if (mar_we) mar_q <= mar_din;
      if (fill)        mdr_q <= fill_data;
      else if (mdr_we) mdr_q <= mdr_din;
    end
  end

  assert_mar_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mar_q));

  assert_mdr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fill) |=> $stable(mdr_q));

  assert_fill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (mdr_q == $past(fill_data)));

  assert_mdr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill && !mdr_load) |=> $stable(mdr_q));

endmodule

// File: rtl/mau_wait.sv
module mau_wait
  import mau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_wait,
  input  logic start_ok,
  input  logic busy,
  input  logic finish,
  output logic stall
);

  assign stall = wait_blocks(step_wait, start_ok, busy, finish);

  assert_stall_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> busy);

  assert_release_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_wait && busy && !stall) |=> !busy);

  assert_join_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_wait && start_ok) |=> busy);

endmodule

// File: rtl/mem_access_unit.sv
module mem_access_unit
  import mau_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    step_cmd,
  input  logic          step_wait,
  input  logic          mar_load,
  input  logic [AW-1:0] mar_din,
  input  logic          mdr_load,
  input  logic [DW-1:0] mdr_din,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] mdr_q,
  output logic          busy,
  output logic          stall,
  output logic          err_issue,
  output logic          err_clobber,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);

  logic start_ok;
  logic finish;
  logic fill;

  mau_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (step_cmd),
    .req_ready (mem_req_ready),
    .rsp_valid (mem_rsp_valid),
    .busy      (busy),
    .start_ok  (start_ok),
    .start_err (err_issue),
    .req_valid (mem_req_valid),
    .req_we    (mem_req_we),
    .finish    (finish),
    .fill      (fill)
  );

  mau_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mar_load  (mar_load),
    .mar_din   (mar_din),
    .mdr_load  (mdr_load),
    .mdr_din   (mdr_din),
    .fill      (fill),
    .fill_data (mem_rsp_data),
    .mar_q     (mar_q),
    .mdr_q     (mdr_q),
    .clobber   (err_clobber)
  );

  mau_wait u_wait (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_wait (step_wait),
    .start_ok  (start_ok),
    .busy      (busy),
    .finish    (finish),
    .stall     (stall)
  );

  assign mem_req_addr  = mar_q;
  assign mem_req_wdata = mdr_q;

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));

  assert_err_no_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_issue && mem_req_valid && mem_req_ready) |=> !mem_req_valid);

endmodule

// File: tb/tb_mem_access_unit.sv
`timescale 1ns/1ps
module tb_mem_access_unit;

  localparam int AW = 16;
  localparam int DW = 32;

  typedef struct packed {
    logic        we;
    logic [1:0]  mode;   // 0 wait with start, 1 wait from next step, 2 no wait
    logic [3:0]  rdly;
    logic [3:0]  sdly;
    logic [15:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 4'd0, 4'd0, 16'h0010, 32'hDEAD_BEEF},
    '{1'b1, 2'd0, 4'd2, 4'd0, 16'h0020, 32'h1234_5678},
    '{1'b0, 2'd1, 4'd3, 4'd2, 16'h8000, 32'hA5A5_0F0F},
    '{1'b1, 2'd1, 4'd0, 4'd0, 16'hFFFF, 32'hFFFF_FFFF},
    '{1'b0, 2'd2, 4'd1, 4'd4, 16'h0004, 32'h0000_0001},
    '{1'b1, 2'd2, 4'd5, 4'd0, 16'h7FFE, 32'h8000_0000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    step_cmd = 2'd0;
  logic          step_wait = 1'b0;
  logic          mar_load = 1'b0;
  logic [AW-1:0] mar_din = '0;
  logic          mdr_load = 1'b0;
  logic [DW-1:0] mdr_din = '0;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] mdr_q;
  logic          busy, stall, err_issue, err_clobber;
  logic          mem_req_valid, mem_req_we;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mem_access_unit #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .step_cmd(step_cmd), .step_wait(step_wait),
    .mar_load(mar_load), .mar_din(mar_din), .mdr_load(mdr_load), .mdr_din(mdr_din),
    .mar_q(mar_q), .mdr_q(mdr_q), .busy(busy), .stall(stall),
    .err_issue(err_issue), .err_clobber(err_clobber),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run_vec(input vec_t v);
    logic w1;
    @(negedge clk);
    mar_load = 1'b1; mar_din = v.addr;
    if (v.we) begin mdr_load = 1'b1; mdr_din = v.data; end
    @(negedge clk);
    mar_load = 1'b0; mdr_load = 1'b0;
    #1;
    chk("R2 mar loaded", mar_q, v.addr);
    if (v.we) chk("R2 mdr loaded", mdr_q, v.data);
    step_cmd  = v.we ? 2'd2 : 2'd1;
    step_wait = (v.mode == 2'd0);
    #0.5;
    chk("R7 stall in start step", stall, v.mode == 2'd0);
    @(negedge clk);
    step_cmd  = 2'd0;
    step_wait = (v.mode != 2'd2);
    w1 = step_wait;
    #1;
    chk("R3 request valid", mem_req_valid, 1);
    chk("R3 request kind", mem_req_we, v.we);
    chk("R3 request addr", mem_req_addr, v.addr);
    if (v.we) chk("R4 store data", mem_req_wdata, v.data);
    for (int i = 0; i < int'(v.rdly); i++) begin
      chk("R6 stall before accept", stall, w1);
      step();
      chk("R3 request held", mem_req_valid, 1);
      chk("R3 addr held", mem_req_addr, v.addr);
    end
    mem_req_ready = 1'b1;
    #0.5;
    chk("R6 stall at accept", stall, v.we ? 1'b0 : w1);
    @(negedge clk);
    mem_req_ready = 1'b0;
    #1;
    if (!v.we) begin
      chk("R5 busy awaiting data", busy, 1);
      for (int i = 0; i < int'(v.sdly); i++) begin
        chk("R6 stall awaiting data", stall, w1);
        step();
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = v.data;
      #0.5;
      chk("R6 stall drops on data", stall, 0);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      chk("R5 load data in mdr", mdr_q, v.data);
    end
    chk("R5 idle after access", busy, 0);
    chk("R3 no request when idle", mem_req_valid, 0);
    step_wait = 1'b1;
    #0.5;
    chk("R6 wait when idle", stall, 0);
    step_wait = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 mar zero", mar_q, 0);
    chk("R1 mdr zero", mdr_q, 0);
    chk("R1 busy low", busy, 0);
    chk("R1 stall low", stall, 0);
    chk("R1 request low", mem_req_valid, 0);
    chk("R1 errors low", {err_issue, err_clobber}, 0);

    // table-driven accesses
    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R2 hold without load
    step();
    chk("R2 mdr held", mdr_q, 32'h8000_0000);
    chk("R2 mar held", mar_q, 16'h7FFE);

    // R8 start while busy
    @(negedge clk);
    mar_load = 1'b1; mar_din = 16'h0AAA;
    @(negedge clk);
    mar_load = 1'b0; step_cmd = 2'd1;
    @(negedge clk);
    step_cmd = 2'd2;
    #1;
    chk("R8 err_issue when busy", err_issue, 1);
    @(negedge clk);
    step_cmd = 2'd0; mem_req_ready = 1'b1;
    #1;
    chk("R8 still the load", mem_req_we, 0);
    @(negedge clk);
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_5555;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    #1;
    chk("R8 load finished", busy, 0);
    chk("R8 no err when idle", err_issue, 0);
    step();
    chk("R8 dropped store not sent", mem_req_valid, 0);

    // R9 register writes while busy
    @(negedge clk);
    mar_load = 1'b1; mar_din = 16'h1234; mdr_load = 1'b1; mdr_din = 32'h55;
    @(negedge clk);
    mar_load = 1'b0; mdr_load = 1'b0; step_cmd = 2'd2;
    @(negedge clk);
    step_cmd = 2'd0;
    mar_load = 1'b1; mar_din = 16'hFFFF; mdr_load = 1'b1; mdr_din = 32'h99;
    #1;
    chk("R9 err_clobber", err_clobber, 1);
    @(negedge clk);
    mar_load = 1'b0; mdr_load = 1'b0;
    #1;
    chk("R9 mar unchanged", mem_req_addr, 16'h1234);
    chk("R9 mdr unchanged", mem_req_wdata, 32'h55);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    #1;
    chk("R9 store finished", busy, 0);

    // R10 stray response and code 3
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0BAD; step_cmd = 2'd3;
    @(negedge clk);
    mem_rsp_valid = 1'b0; step_cmd = 2'd0;
    #1;
    chk("R10 stray data ignored", mdr_q, 32'h55);
    chk("R10 code 3 starts nothing", mem_req_valid, 0);
    chk("R10 code 3 leaves idle", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule